// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of per-frame completion status bytes for a transmitter. Each time the transmit engine finishes a frame it presents a one-cycle push together with four outcome flags (interrupt-on-success requested, jabber, underrun, maximum collisions). The block turns these into a status byte with the "complete" bit set. The host reads the oldest unread byte at a byte-wide port, and writing that port (a one-cycle strobe) discards it so the next entry moves to the top.

When the queue is full and another completion arrives, the new byte is lost. The loss is recorded by setting an overflow bit in the newest byte still held. A jabber or underrun outcome leaves the transmitter halted until a transmit reset is applied, and the block reports this on a halted flag. A pending flag tells interrupt logic that at least one status byte is waiting.

Occupancy is tracked by a three-state machine: EMPTY (no entries), PARTIAL (between one and DEPTH-1 entries) and FULL (DEPTH entries). The transitions are: EMPTY to PARTIAL on an accepted push; PARTIAL to FULL on a push without a pop when one slot remains; PARTIAL to EMPTY on a pop without a push when one entry remains; FULL to PARTIAL on a pop without a push. Every other case holds the state. A transmit reset or a system reset returns the machine to EMPTY from any state. DEPTH must be at least 2.

Top module: `txs_stack`

## Requirements
- R1: While and after `rst_n` is low, `stat_rd` reads 0x00 and `stat_pending` and `tx_halted` are low.
- R2: An accepted push stores a byte with bit 7 = 1, bit 6 = `push_flags[3]` (interrupt on success requested), bit 5 = `push_flags[2]` (jabber), bit 4 = `push_flags[1]` (underrun), bit 3 = `push_flags[0]` (maximum collisions), bit 2 = 0 and bits 1:0 = 0. The byte is visible on `stat_rd` from the cycle after the push edge when it is the oldest entry.
- R3: Up to DEPTH (default 4) entries are held. They are presented oldest first.
- R4: A `host_wr` pulse with at least one entry held removes the top entry. The next-oldest entry appears on `stat_rd` after that edge.
- R5: With no entries held, `stat_rd` reads 0x00 and a `host_wr` pulse has no effect.
- R6: A push while FULL with no pop in the same cycle discards the new byte and sets bit 2 of the newest held entry. The other entries and the count are unchanged.
- R7: A push and a pop in the same cycle while FULL removes the oldest entry and stores the new one, with no overflow mark.
- R8: A push and a pop in the same cycle while EMPTY ignores the pop and stores the new entry.
- R9: `stat_pending` is high exactly when at least one entry is held.
- R10: `tx_halted` rises after any push whose jabber or underrun flag is set, including a push discarded by overflow. It then stays high until `tx_reset`.
- R11: A `tx_reset` pulse clears all entries and `tx_halted`. It takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_reset | input | 1 | Transmitter reset: clears queue and halted flag |
| push | input | 1 | Frame completion strobe from the transmit engine |
| push_flags | input | 4 | {intr request, jabber, underrun, max collisions} |
| host_wr | input | 1 | Host write to the status port: pops top entry |
| stat_rd | output | 8 | Oldest status byte, or 0x00 when empty |
| stat_pending | output | 1 | At least one status byte held |
| tx_halted | output | 1 | Transmitter needs a reset after jabber or underrun |

## Verification
A wrong occupancy state or pointer shows at the port one cycle after the edge that caused it. A stuck or early EMPTY state makes `stat_rd` read 0x00 while entries remain. A misplaced pointer makes the bytes come out in the wrong order or repeat. A wrong overflow index marks an older entry with bit 2 instead of the newest one. That error stays hidden until the host has popped down to the marked byte, which can be up to DEPTH pops later. An error in the halted flag is visible on `tx_halted` in the cycle after the push or reset.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int FLAG_W   = 4;
    localparam int STAT_W   = 8;
    localparam int BIT_DONE = 7;
    localparam int BIT_OVF  = 2;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;

    // flags: [3] intr request, [2] jabber, [1] underrun, [0] max collisions
    function automatic logic [STAT_W-1:0] make_entry(input logic [FLAG_W-1:0] flags);
        return {1'b1, flags, 3'b000};
    endfunction

    function automatic logic needs_reset(input logic [FLAG_W-1:0] flags);
        return flags[2] | flags[1];
    endfunction

endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_reset,
    input  logic             push,
    input  logic             pop,
    output occ_state_e       state,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             mark_en,
    output logic [IDX_W-1:0] mark_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] wr_q, rd_q;
    logic             pop_ok, push_ok, drop;

    always_comb begin
        pop_ok  = pop && (state_q != OCC_EMPTY);
        push_ok = push && ((state_q != OCC_FULL) || pop_ok);
        drop    = push && (state_q == OCC_FULL) && !pop_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY:
                if (push_ok) state_d = OCC_PARTIAL;
            OCC_PARTIAL:
                if (push_ok && !pop_ok && cnt_q == CNT_MAX - 1'b1)
                    state_d = OCC_FULL;
                else if (pop_ok && !push_ok && cnt_q == CNT_W'(1))
                    state_d = OCC_EMPTY;
            OCC_FULL:
                if (pop_ok && !push_ok) state_d = OCC_PARTIAL;
            default:
                state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || tx_reset) state_q <= OCC_EMPTY;
        else                    state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || tx_reset) begin
            cnt_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
            if (push_ok) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
        end
    end

    always_comb begin
        state    = state_q;
        wr_en    = push_ok && !tx_reset;
        wr_idx   = wr_q;
        rd_idx   = rd_q;
        mark_en  = drop && !tx_reset;
        mark_idx = (wr_q == '0) ? LAST_IDX : wr_q - 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);  // R3
    AST_EMPTY_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (cnt_q == '0));  // R9
    AST_FULL_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == (cnt_q == CNT_MAX));  // R3
    AST_DROP_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL && push && !pop && !tx_reset) |=> state_q == OCC_FULL);  // R6
    AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY && pop && !push && !tx_reset) |=> state_q == OCC_EMPTY);  // R5
    AST_TXRESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> state_q == OCC_EMPTY);  // R11

endmodule

// File: rtl/txs_store.sv
module txs_store
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [STAT_W-1:0] rd_data
);

    logic [STAT_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                slot[i] <= wr_data;
            else if (mark_en && mark_idx == IDX_W'(i))
                slot[i][BIT_OVF] <= 1'b1;
        end
    end

    assign rd_data = slot[rd_idx];

    AST_MARK_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && mark_en));  // R6

endmodule

// File: rtl/txs_halt.sv
module txs_halt
    import txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_reset,
    input  logic              push,
    input  logic [FLAG_W-1:0] push_flags,
    output logic              halted
);

    always_ff @(posedge clk) begin
        if (!rst_n || tx_reset)                halted <= 1'b0;
        else if (push && needs_reset(push_flags)) halted <= 1'b1;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !tx_reset) |=> halted);  // R10
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> !halted);  // R11

endmodule

// File: rtl/txs_stack.sv
module txs_stack
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_reset,
    input  logic       push,
    input  logic [3:0] push_flags,
    input  logic       host_wr,
    output logic [7:0] stat_rd,
    output logic       stat_pending,
    output logic       tx_halted
);

    occ_state_e        state;
    logic              wr_en, mark_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx, mark_idx;
    logic [STAT_W-1:0] top_byte;

    txs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_reset (tx_reset),
        .push     (push),
        .pop      (host_wr),
        .state    (state),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .mark_en  (mark_en),
        .mark_idx (mark_idx)
    );

    txs_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (make_entry(push_flags)),
        .mark_en  (mark_en),
        .mark_idx (mark_idx),
        .rd_idx   (rd_idx),
        .rd_data  (top_byte)
    );

    txs_halt u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_reset   (tx_reset),
        .push       (push),
        .push_flags (push_flags),
        .halted     (tx_halted)
    );

    always_comb begin
        stat_pending = (state != OCC_EMPTY);
        stat_rd      = stat_pending ? top_byte : '0;
    end

    AST_TOP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pending |-> (stat_rd[BIT_DONE] && stat_rd[1:0] == 2'b00));  // R2
    AST_FULL_PUSH_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL && push && !host_wr) |-> !wr_en);  // R6

endmodule

// File: tb/txs_stack_test.sv
module txs_stack_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_reset = 1'b0;
    logic       push = 1'b0;
    logic [3:0] push_flags = 4'h0;
    logic       host_wr = 1'b0;
    logic [7:0] stat_rd;
    logic       stat_pending;
    logic       tx_halted;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    txs_stack uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_reset     (tx_reset),
        .push         (push),
        .push_flags   (push_flags),
        .host_wr      (host_wr),
        .stat_rd      (stat_rd),
        .stat_pending (stat_pending),
        .tx_halted    (tx_halted)
    );

    // row: {push, flags[3:0], pop, exp_rd[7:0], exp_pend, exp_halt}
    localparam int NV = 25;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 4'h0, 1'b0, 8'h80, 1'b1, 1'b0},  // 0  R2
        {1'b1, 4'h1, 1'b0, 8'h80, 1'b1, 1'b0},  // 1  R3
        {1'b0, 4'h0, 1'b1, 8'h88, 1'b1, 1'b0},  // 2  R4
        {1'b0, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0},  // 3  R9
        {1'b0, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0},  // 4  R5
        {1'b1, 4'h8, 1'b1, 8'hC0, 1'b1, 1'b0},  // 5  R8
        {1'b1, 4'h9, 1'b0, 8'hC0, 1'b1, 1'b0},  // 6  R3
        {1'b1, 4'h0, 1'b0, 8'hC0, 1'b1, 1'b0},  // 7  R3
        {1'b1, 4'h1, 1'b0, 8'hC0, 1'b1, 1'b0},  // 8  R3
        {1'b1, 4'h8, 1'b0, 8'hC0, 1'b1, 1'b0},  // 9  R6
        {1'b0, 4'h0, 1'b1, 8'hC8, 1'b1, 1'b0},  // 10 R6
        {1'b0, 4'h0, 1'b1, 8'h80, 1'b1, 1'b0},  // 11 R6
        {1'b0, 4'h0, 1'b1, 8'h8C, 1'b1, 1'b0},  // 12 R6
        {1'b0, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0},  // 13 R9
        {1'b1, 4'h0, 1'b0, 8'h80, 1'b1, 1'b0},  // 14 R3
        {1'b1, 4'h1, 1'b0, 8'h80, 1'b1, 1'b0},  // 15 R3
        {1'b1, 4'h8, 1'b0, 8'h80, 1'b1, 1'b0},  // 16 R3
        {1'b1, 4'h9, 1'b0, 8'h80, 1'b1, 1'b0},  // 17 R3
        {1'b1, 4'h0, 1'b1, 8'h88, 1'b1, 1'b0},  // 18 R7
        {1'b0, 4'h0, 1'b1, 8'hC0, 1'b1, 1'b0},  // 19 R7
        {1'b0, 4'h0, 1'b1, 8'hC8, 1'b1, 1'b0},  // 20 R7
        {1'b0, 4'h0, 1'b1, 8'h80, 1'b1, 1'b0},  // 21 R7
        {1'b0, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0},  // 22 R9
        {1'b1, 4'h2, 1'b0, 8'h90, 1'b1, 1'b1},  // 23 R10
        {1'b0, 4'h0, 1'b1, 8'h00, 1'b0, 1'b1}   // 24 R10
    };

    function automatic string row_tag(input int i);
        case (i)
            0:                    return "R2";
            2:                    return "R4";
            4:                    return "R5";
            5:                    return "R8";
            9, 10, 11, 12:        return "R6";
            18, 19, 20, 21:       return "R7";
            3, 13, 22:            return "R9";
            23, 24:               return "R10";
            default:              return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] exp_rd,
                         input logic exp_pend, input logic exp_halt);
        total++;
        if (stat_rd !== exp_rd || stat_pending !== exp_pend || tx_halted !== exp_halt) begin
            bad++;
            $display("FAIL %s: rd=%02h pend=%0b halt=%0b expected rd=%02h pend=%0b halt=%0b",
                     tag, stat_rd, stat_pending, tx_halted, exp_rd, exp_pend, exp_halt);
        end
    endtask

    task automatic step(input logic p, input logic [3:0] f, input logic w, input logic tr);
        @(negedge clk);
        push = p; push_flags = f; host_wr = w; tx_reset = tr;
        @(posedge clk);
        #2;
        @(negedge clk);
        push = 1'b0; push_flags = 4'h0; host_wr = 1'b0; tx_reset = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][15], VEC[i][14:11], VEC[i][10], 1'b0);
            check(row_tag(i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R11: transmit reset clears halted flag
        step(1'b0, 4'h0, 1'b0, 1'b1);
        check("R11 halt cleared", 8'h00, 1'b0, 1'b0);

        // R10: jabber status dropped on overflow still halts; newest entry marked (R6)
        for (int k = 0; k < 4; k++) step(1'b1, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'h4, 1'b0, 1'b0);
        check("R10 halt on dropped jabber", 8'h80, 1'b1, 1'b1);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R6 newest marked", 8'h84, 1'b1, 1'b1);

        // R11: tx_reset with full-ish queue and simultaneous push wins
        step(1'b1, 4'h1, 1'b0, 1'b0);
        step(1'b1, 4'h8, 1'b1, 1'b1);
        check("R11 reset wins over push/pop", 8'h00, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R11 queue stays empty", 8'h00, 1'b0, 1'b0);

        // R1: system reset mid-operation
        step(1'b1, 4'h2, 1'b0, 1'b0);
        check("R10 underrun halts", 8'h90, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears all", 8'h00, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule